// File: doc/BRIEF.md
# Six-Channel DAC Code Offset Corrector

This block sits in the sample path ahead of a digital-to-analog converter. Each of its six channels has three registers: a signed offset held in offset-binary form, a range selector, and a sticky error flag. Every accepted sample is added to its channel's offset in a signed adder that has two guard bits. The sum is compared with the legal code window for the channel's output range. A sum inside the window passes unchanged. A sum outside the window is clamped to the nearer window limit, flagged on the output, and recorded in the channel's sticky error flag.

A small register port writes and reads the configuration. For each channel the offset, range and status registers sit at consecutive addresses, and the channels are spaced four addresses apart. Software clears a status flag by writing a one to bit 0.

Top module: `dac_offset_corrector`

## Requirements
- R1: Channel n (0..5) has its offset register at address 0601H+4n, its range register at 0602H+4n and its status register at 0603H+4n. A read strobe returns data on reg_rdata in the next cycle. An unmapped address reads as zero.
- R2: After reset every offset register reads 8000H, every range register reads 0, every status flag reads 0, and out_valid is low.
- R3: The offset word is offset binary: 8000H means zero, 0000H means -32768, FFFFH means +32767 and 7FE2H means -30. For an in-window result, out_code equals in_code plus (offset word - 32768).
- R4: Range value 1 selects the window 655..64880. Range value 0, and the unsupported values 2 and 3, select the window 328..65207. The range register keeps and reads back only bits [1:0].
- R5: A sum below the window's lower limit gives out_code equal to that limit. A sum above the upper limit gives out_code equal to that limit. In both cases out_oor is 1. Inside the window (limits included) out_oor is 0. Sums up to 98302 and down to -32768 are compared without wraparound.
- R6: An accepted sample produces exactly one result in the next cycle: out_valid is high and out_chan equals the sample's channel. With no sample, out_valid stays low.
- R7: A sample whose channel index is 6 or 7 produces no output and sets no status flag.
- R8: Status bit 0 is set by an out-of-range result on that channel and stays set until a write with bit 0 high clears it. A write with bit 0 low leaves it unchanged. When a set and a clear fall in the same cycle, the set wins.
- R9: A register write applies to samples presented in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 3 | Sample channel index |
| in_code | input | 16 | Uncorrected sample code |
| out_valid | output | 1 | Result strobe, one cycle after the sample |
| out_chan | output | 3 | Result channel index |
| out_code | output | 16 | Corrected and clamped code |
| out_oor | output | 1 | Result was clamped |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after reg_rd |

## Verification
A sample result appears one cycle after the sample, and read data appears one cycle after the read strobe. A status flag changes on the same edge that registers the result that caused it. The bench drives every stimulus on a falling edge and samples the matching response on the next falling edge, so the single rising edge in between is the one that registers it. Status flags are read only after the sample's cycle has ended. For the set-versus-clear case, the sample and the clearing write are driven on the same falling edge, and the flag is read back afterwards.

// File: rtl/dacoff_pkg.sv
package dacoff_pkg;
   localparam int RSEL_W = 2;
   typedef enum logic [RSEL_W-1:0] {
      RSEL_VOLT = 2'd0,
      RSEL_CURR = 2'd1
   } rsel_e;
endpackage

// File: rtl/dacoff_regs.sv
module dacoff_regs
   import dacoff_pkg::*;
#(
   parameter int NUM_CH    = 6,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 16'h0600,
   parameter int STRIDE    = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_i,
   input  logic                           rd_i,
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [DATA_W-1:0]              wdata_i,
   output logic [DATA_W-1:0]              rdata_o,
   input  logic [NUM_CH-1:0]              err_set_i,
   output logic [NUM_CH-1:0][DATA_W-1:0]  offs_o,
   output logic [NUM_CH-1:0][RSEL_W-1:0]  rsel_o,
   output logic [NUM_CH-1:0]              err_o
);
   localparam logic [DATA_W-1:0] OFF_ZERO = DATA_W'(1) << (DATA_W-1);

   if (STRIDE < 3) begin : g_bad_stride
      $error("dacoff_regs: STRIDE must leave room for three registers");
   end
   if (DATA_W < RSEL_W) begin : g_bad_width
      $error("dacoff_regs: DATA_W too narrow");
   end

   logic [NUM_CH-1:0][DATA_W-1:0] rd_term;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(BASE_ADDR + STRIDE*c + 1);
      localparam logic [ADDR_W-1:0] A_RSEL = ADDR_W'(BASE_ADDR + STRIDE*c + 2);
      localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_ADDR + STRIDE*c + 3);

      logic hit_off, hit_rsel, hit_stat, clr;
      assign hit_off  = (addr_i == A_OFF);
      assign hit_rsel = (addr_i == A_RSEL);
      assign hit_stat = (addr_i == A_STAT);
      assign clr      = wr_i && hit_stat && wdata_i[0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            offs_o[c] <= OFF_ZERO;
            rsel_o[c] <= RSEL_VOLT;
            err_o[c]  <= 1'b0;
         end else begin
            if (wr_i && hit_off)  offs_o[c] <= wdata_i;
            if (wr_i && hit_rsel) rsel_o[c] <= wdata_i[RSEL_W-1:0];
            if (err_set_i[c])     err_o[c]  <= 1'b1;
            else if (clr)         err_o[c]  <= 1'b0;
         end
      end

      always_comb begin
         rd_term[c] = '0;
         if (hit_off)       rd_term[c] = offs_o[c];
         else if (hit_rsel) rd_term[c] = DATA_W'(rsel_o[c]);
         else if (hit_stat) rd_term[c] = DATA_W'(err_o[c]);
      end

      p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         err_o[c] && !clr |=> err_o[c]);
      p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
         err_set_i[c] |=> err_o[c]);
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CH; c++) rd_mux = rd_mux | rd_term[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_o <= '0;
      else if (rd_i)  rdata_o <= rd_mux;
      else            rdata_o <= '0;
   end
endmodule

// File: rtl/dacoff_corrector.sv
module dacoff_corrector
   import dacoff_pkg::*;
#(
   parameter int CODE_W = 16,
   parameter int GUARD  = 2,
   parameter int V_LO   = 328,
   parameter int V_HI   = 65207,
   parameter int I_LO   = 655,
   parameter int I_HI   = 64880
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [CODE_W-1:0] off_i,
   input  logic [RSEL_W-1:0] rsel_i,
   output logic [CODE_W-1:0] code_o,
   output logic              oor_o
);
   localparam int SUM_W = CODE_W + GUARD;
   localparam int CMAX  = (1 << CODE_W) - 1;

   if (GUARD < 2) begin : g_bad_guard
      $error("dacoff_corrector: need two guard bits for a wrap-free sum");
   end
   if (V_LO > V_HI || I_LO > I_HI || V_HI > CMAX || I_HI > CMAX) begin : g_bad_win
      $error("dacoff_corrector: window limits inconsistent");
   end

   localparam logic signed [SUM_W-1:0] BIAS = SUM_W'(1) <<< (CODE_W-1);

   logic signed [SUM_W-1:0] s_code, s_off, sum, lo, hi;

   always_comb begin
      s_code = $signed(SUM_W'(code_i));
      s_off  = $signed(SUM_W'(off_i)) - BIAS;
      sum    = s_code + s_off;
      if (rsel_i == RSEL_CURR) begin
         lo = SUM_W'(I_LO);
         hi = SUM_W'(I_HI);
      end else begin
         lo = SUM_W'(V_LO);
         hi = SUM_W'(V_HI);
      end
      if (sum < lo) begin
         code_o = lo[CODE_W-1:0];
         oor_o  = 1'b1;
      end else if (sum > hi) begin
         code_o = hi[CODE_W-1:0];
         oor_o  = 1'b1;
      end else begin
         code_o = sum[CODE_W-1:0];
         oor_o  = 1'b0;
      end
   end
endmodule

// File: rtl/dac_offset_corrector.sv
module dac_offset_corrector
   import dacoff_pkg::*;
#(
   parameter int NUM_CH    = 6,
   parameter int CODE_W    = 16,
   parameter int CH_W      = 3,
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 16'h0600,
   parameter int STRIDE    = 4,
   parameter int V_LO      = 328,
   parameter int V_HI      = 65207,
   parameter int I_LO      = 655,
   parameter int I_HI      = 64880
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CH_W-1:0]   in_chan,
   input  logic [CODE_W-1:0] in_code,
   output logic              out_valid,
   output logic [CH_W-1:0]   out_chan,
   output logic [CODE_W-1:0] out_code,
   output logic              out_oor,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CODE_W-1:0] reg_wdata,
   output logic [CODE_W-1:0] reg_rdata
);
   if ((1 << CH_W) < NUM_CH) begin : g_bad_chw
      $error("dac_offset_corrector: CH_W too narrow for NUM_CH");
   end

   logic [NUM_CH-1:0][CODE_W-1:0] offs;
   logic [NUM_CH-1:0][RSEL_W-1:0] rsel;
   logic [NUM_CH-1:0]             err_flag, err_set;

   logic              ch_ok;
   logic [CH_W-1:0]   sel;
   logic [CODE_W-1:0] corr_code;
   logic              corr_oor;

   assign ch_ok = ({1'b0, in_chan} < (CH_W+1)'(NUM_CH));
   assign sel   = ch_ok ? in_chan : '0;

   dacoff_regs #(
      .NUM_CH(NUM_CH), .DATA_W(CODE_W), .ADDR_W(ADDR_W),
      .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata),
      .err_set_i(err_set), .offs_o(offs), .rsel_o(rsel), .err_o(err_flag)
   );

   dacoff_corrector #(
      .CODE_W(CODE_W), .GUARD(2),
      .V_LO(V_LO), .V_HI(V_HI), .I_LO(I_LO), .I_HI(I_HI)
   ) i_corr (
      .code_i(in_code), .off_i(offs[sel]), .rsel_i(rsel[sel]),
      .code_o(corr_code), .oor_o(corr_oor)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_set
      assign err_set[c] = in_valid && ch_ok && (sel == CH_W'(c)) && corr_oor;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chan  <= '0;
         out_code  <= '0;
         out_oor   <= 1'b0;
      end else begin
         out_valid <= in_valid && ch_ok;
         if (in_valid && ch_ok) begin
            out_chan <= in_chan;
            out_code <= corr_code;
            out_oor  <= corr_oor;
         end
      end
   end

   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ch_ok |=> out_valid && out_chan == $past(in_chan));
   p_bad_chan_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && ch_ok) |=> !out_valid);
   p_clamp_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_oor |-> (out_code == CODE_W'(V_LO) || out_code == CODE_W'(V_HI) ||
                                out_code == CODE_W'(I_LO) || out_code == CODE_W'(I_HI)));
   p_oor_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_oor |-> err_flag[out_chan]);
endmodule

// File: tb/test_dac_offset_corrector.sv
module test_dac_offset_corrector;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_chan = '0;
   logic [15:0] in_code = '0;
   logic        out_valid, out_oor;
   logic [2:0]  out_chan;
   logic [15:0] out_code, reg_rdata;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_addr = '0, reg_wdata = '0;

   int checks = 0, errors = 0;
   bit finished = 0;

   logic [15:0] m_off  [6];
   logic [1:0]  m_rsel [6];
   logic        m_flag [6];

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_offset_corrector i_dac_offset_corrector (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .in_code(in_code), .out_valid(out_valid), .out_chan(out_chan),
      .out_code(out_code), .out_oor(out_oor), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic logic [15:0] a_off(int ch);  return 16'(16'h0601 + 4*ch); endfunction
   function automatic logic [15:0] a_rsel(int ch); return 16'(16'h0602 + 4*ch); endfunction
   function automatic logic [15:0] a_stat(int ch); return 16'(16'h0603 + 4*ch); endfunction

   function automatic logic [16:0] model(int ch, logic [15:0] code);
      int s, lo, hi;
      s  = int'(code) + int'(m_off[ch]) - 32768;
      lo = (m_rsel[ch] == 2'd1) ? 655 : 328;
      hi = (m_rsel[ch] == 2'd1) ? 64880 : 65207;
      if (s < lo) return {1'b1, 16'(lo)};
      if (s > hi) return {1'b1, 16'(hi)};
      return {1'b0, 16'(s)};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] addr, logic [15:0] data);
      reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
      for (int c = 0; c < 6; c++) begin
         if (addr == a_off(c))  m_off[c]  = data;
         if (addr == a_rsel(c)) m_rsel[c] = data[1:0];
         if (addr == a_stat(c) && data[0]) m_flag[c] = 1'b0;
      end
   endtask

   task automatic rd(logic [15:0] addr, output logic [15:0] val);
      reg_rd = 1'b1; reg_addr = addr;
      @(negedge clk);
      reg_rd = 1'b0;
      val = reg_rdata;
   endtask

   task automatic send(string req, int ch, logic [15:0] code);
      logic [16:0] e;
      in_valid = 1'b1; in_chan = 3'(ch); in_code = code;
      @(negedge clk);
      in_valid = 1'b0;
      if (ch < 6) begin
         e = model(ch, code);
         check({req, " valid"}, 32'(out_valid), 32'd1);
         check({req, " chan"},  32'(out_chan), 32'(ch));
         check({req, " code"},  32'(out_code), 32'(e[15:0]));
         check({req, " oor"},   32'(out_oor), 32'(e[16]));
         if (e[16]) m_flag[ch] = 1'b1;
      end else begin
         check({req, " no output"}, 32'(out_valid), 32'd0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd20240611));
      for (int c = 0; c < 6; c++) begin
         m_off[c] = 16'h8000; m_rsel[c] = 2'd0; m_flag[c] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state, R1 address map
      check("R2 out_valid after reset", 32'(out_valid), 32'd0);
      for (int c = 0; c < 6; c++) begin
         rd(a_off(c), v);  check("R2 R1 offset reset", 32'(v), 32'h8000);
         rd(a_rsel(c), v); check("R2 R1 range reset", 32'(v), 32'd0);
         rd(a_stat(c), v); check("R2 R1 flag reset", 32'(v), 32'd0);
      end
      rd(16'h0600, v); check("R1 unmapped read", 32'(v), 32'd0);
      rd(16'h0619, v); check("R1 unmapped read past last", 32'(v), 32'd0);
      wr(a_off(4), 16'h1234);
      rd(a_off(4), v);  check("R1 offset readback", 32'(v), 32'h1234);
      rd(a_off(3), v);  check("R1 neighbour untouched", 32'(v), 32'h8000);
      wr(a_rsel(5), 16'hFFFD);
      rd(a_rsel(5), v); check("R4 range keeps two bits", 32'(v), 32'd1);

      // R3 offset binary arithmetic
      wr(a_off(0), 16'h7FE2);
      send("R3 minus 30", 0, 16'd1000);
      check("R3 minus 30 value", 32'(out_code), 32'd970);
      wr(a_off(0), 16'h8001);
      send("R3 plus one", 0, 16'd500);
      wr(a_off(0), 16'h8000);
      send("R3 zero offset", 0, 16'd30000);

      // R5 voltage window edges
      send("R5 at low limit", 0, 16'd328);
      send("R5 below low", 0, 16'd327);
      check("R5 clamp low value", 32'(out_code), 32'd328);
      send("R5 at high limit", 0, 16'd65207);
      send("R5 above high", 0, 16'd65208);
      check("R5 clamp high value", 32'(out_code), 32'd65207);
      wr(a_off(1), 16'hFFFF);
      send("R5 no wrap high", 1, 16'hFFFF);
      wr(a_off(1), 16'h0000);
      send("R5 no wrap low", 1, 16'h0000);

      // R4 current window and unsupported encodings
      wr(a_rsel(2), 16'd1);
      send("R4 current below", 2, 16'd654);
      send("R4 current at low", 2, 16'd655);
      send("R4 current above", 2, 16'd64881);
      send("R4 current at high", 2, 16'd64880);
      wr(a_rsel(3), 16'd2);
      send("R4 code 2 voltage", 3, 16'd400);
      check("R4 code 2 not clamped", 32'(out_oor), 32'd0);

      // R7 illegal channel indices
      for (int c = 0; c < 6; c++) wr(a_stat(c), 16'h0001);
      wr(a_off(0), 16'h0000);
      send("R7 chan 6", 6, 16'd0);
      send("R7 chan 7", 7, 16'd0);
      for (int c = 0; c < 6; c++) begin
         rd(a_stat(c), v); check("R7 no flag set", 32'(v), 32'd0);
      end
      wr(a_off(0), 16'h8000);

      // R6 idle cycle produces nothing
      @(negedge clk);
      check("R6 idle no output", 32'(out_valid), 32'd0);

      // R8 sticky flag behaviour
      send("R8 set", 2, 16'd10);
      rd(a_stat(2), v); check("R8 flag set", 32'(v), 32'd1);
      send("R8 in window keeps", 2, 16'd1000);
      wr(a_stat(2), 16'hFFFE);
      rd(a_stat(2), v); check("R8 write zero no effect", 32'(v), 32'd1);
      wr(a_stat(2), 16'h0001);
      rd(a_stat(2), v); check("R8 cleared", 32'(v), 32'd0);
      in_valid = 1'b1; in_chan = 3'd2; in_code = 16'd5;
      reg_wr = 1'b1; reg_addr = a_stat(2); reg_wdata = 16'h0001;
      @(negedge clk);
      in_valid = 1'b0; reg_wr = 1'b0;
      check("R8 simultaneous oor", 32'(out_oor), 32'd1);
      m_flag[2] = 1'b1;
      rd(a_stat(2), v); check("R8 set wins over clear", 32'(v), 32'd1);

      // R9 write applies to the next cycle's sample
      wr(a_off(5), 16'h8064);
      send("R9 new offset used", 5, 16'd20000);
      check("R9 value", 32'(out_code), 32'd20100);

      // random mix, R3 R5 R6
      for (int i = 0; i < 600; i++) begin
         int ch, r;
         r  = int'($urandom_range(0, 15));
         ch = int'($urandom_range(0, 5));
         if (r == 0)      wr(a_off(ch), 16'($urandom_range(16'h7000, 16'h9000)));
         else if (r == 1) wr(a_off(ch), 16'($urandom));
         else if (r == 2) wr(a_rsel(ch), 16'($urandom_range(0, 3)));
         else if (r == 3) wr(a_stat(ch), 16'($urandom));
         else if (r == 4) @(negedge clk);
         else if (r == 5) send("R5 random edge", ch, 16'($urandom_range(0, 1000)));
         else             send("R3 random", ch, 16'($urandom));
      end
      for (int c = 0; c < 6; c++) begin
         rd(a_stat(c), v); check("R8 random flags", 32'(v), 32'(m_flag[c]));
         rd(a_off(c), v);  check("R1 random offsets", 32'(v), 32'(m_off[c]));
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule